// File: doc/BRIEF.md
# Link Word Parity Error Counter

This block sits on the receive side of a serial trigger link. Each bunch-crossing clock it may receive a 15-bit word made of a 12-bit pad field, a 2-bit bunch-crossing field and one parity bit. The sender sets the parity bit so that the whole word holds an even number of ones. The receiver applies the same rule to every qualified word, raises a one-cycle error flag for each word that breaks it, and counts the mismatches.

The count is how the host measures link quality. The host clears the counter, lets the link run for a fixed interval, then reads the count. Repeating this at each sampling-phase setting shows which settings give an error-free window. The count stops at its maximum value instead of wrapping, so a heavily corrupted link never reads as a clean one. The host can read the count at any moment.

Top module: `link_parity_monitor`

## Requirements
- R1: While reset is high at a clock edge, the count goes to zero and the error flag goes low.
- R2: The word has three fields. Bits 11:0 are pad data, bits 13:12 are the bunch-crossing number and bit 14 is the parity bit. A word is good when the number of ones across all 15 bits is even, and bad when it is odd.
- R3: The error flag is registered. It is high in the cycle that follows the clock edge at which a bad word was sampled with valid high. It is low after an edge that sampled a good word.
- R4: Each bad word sampled with valid high adds exactly one to the count, and the new value is visible after that same clock edge.
- R5: When valid is low at an edge, the word is ignored. The flag is low after that edge and the count does not change.
- R6: The count saturates at all ones (0xFFFF at the default 16-bit width). Further bad words leave it there.
- R7: A clear strobe sets the count to zero at that edge. This also happens when a bad word arrives at the same edge, because clear takes priority over the increment.
- R8: The count output is always readable and holds its value across edges that have no bad valid word and no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_i | input | 1 | Synchronous active-high reset |
| word_i | input | 15 | Received link word (pad, bunch crossing, parity) |
| valid_i | input | 1 | Qualifies word_i for checking |
| clear_i | input | 1 | Host strobe that zeroes the counter |
| err_o | output | 1 | Registered flag for a bad word seen at the previous edge |
| err_count_o | output | CNT_W (16) | Saturating count of bad words |

## Verification
The bench drives every one of the 32768 possible words. Because each bad word has its own single-cycle flag, a parity rule that used odd parity or left out one field would show up on one specific word pattern. The bench uses a narrow counter so that the count reaches its limit many times over. A counter that wraps, or one that stops one value short of all ones, would then show a small count where the bench expects the maximum. Clear strobes are placed so that some of them land on bad words. A design that let the increment win would then read one instead of zero. A final sweep drives bad words with valid low and catches any design that counts or flags unqualified words.

// File: rtl/link_parity_pkg.sv
package link_parity_pkg;

  localparam int LP_PAD_W = 12;
  localparam int LP_BX_W  = 2;
  localparam int LP_CNT_W = 16;

  typedef enum logic {
    VERDICT_GOOD = 1'b0,
    VERDICT_BAD  = 1'b1
  } verdict_e;

endpackage

// File: rtl/lp_parity_check.sv
module lp_parity_check
  import link_parity_pkg::*;
#(
  parameter int PAD_W = LP_PAD_W,
  parameter int BX_W  = LP_BX_W,
  localparam int WORD_W = PAD_W + BX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              bad_o,
  output logic              flag_o
);

  localparam int PAR_BIT = WORD_W - 1;

  logic     payload_odd;
  verdict_e verdict;

  // the parity bit must make the whole word even
  assign payload_odd = ^word_i[PAR_BIT-1:0];
  assign verdict     = (payload_odd != word_i[PAR_BIT]) ? VERDICT_BAD : VERDICT_GOOD;
  assign bad_o       = valid_i && (verdict == VERDICT_BAD);

  always_ff @(posedge clk_i) begin
    if (rst_i) flag_o <= 1'b0;
    else       flag_o <= bad_o;
  end

  // R5
  no_flag_unqualified_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_i |=> !flag_o);

  // R3
  flag_follows_odd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && ^word_i) |=> flag_o);

endmodule

// File: rtl/lp_sat_counter.sv
module lp_sat_counter
  import link_parity_pkg::*;
#(
  parameter int CNT_W = LP_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic at_max;
  assign at_max = (cnt_o == CNT_MAX);

  always_ff @(posedge clk_i) begin
    if (rst_i)                 cnt_o <= '0;
    else if (clr_i)            cnt_o <= '0;
    else if (inc_i && !at_max) cnt_o <= cnt_o + 1'b1;
  end

  // R7
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (cnt_o == '0));

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!clr_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));

  // R4
  single_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!clr_i && inc_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!clr_i && !inc_i) |=> $stable(cnt_o));

endmodule

// File: rtl/link_parity_monitor.sv
module link_parity_monitor
  import link_parity_pkg::*;
#(
  parameter int PAD_W = LP_PAD_W,
  parameter int BX_W  = LP_BX_W,
  parameter int CNT_W = LP_CNT_W,
  localparam int WORD_W = PAD_W + BX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  input  logic              clear_i,
  output logic              err_o,
  output logic [CNT_W-1:0]  err_count_o
);

  logic bad_word;

  lp_parity_check #(
    .PAD_W (PAD_W),
    .BX_W  (BX_W)
  ) u_check (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .word_i  (word_i),
    .valid_i (valid_i),
    .bad_o   (bad_word),
    .flag_o  (err_o)
  );

  lp_sat_counter #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .inc_i (bad_word),
    .clr_i (clear_i),
    .cnt_o (err_count_o)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    rst_i |=> (!err_o && err_count_o == '0));

endmodule

// File: tb/link_parity_monitor_tb.sv
`timescale 1ns/1ps
module link_parity_monitor_tb;

  localparam int CW = 6;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic          clk = 1'b0;
  logic          rst;
  logic [14:0]   word;
  logic          valid;
  logic          clear;
  logic          err;
  logic [CW-1:0] cnt;

  int checks = 0;
  int fails  = 0;
  logic          exp_err;
  logic [CW-1:0] exp_cnt;

  always #5 clk = ~clk;

  link_parity_monitor #(.PAD_W(12), .BX_W(2), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_i(rst), .word_i(word), .valid_i(valid),
    .clear_i(clear), .err_o(err), .err_count_o(cnt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [14:0] w, input logic v, input logic c);
    string tag;
    @(negedge clk);
    word = w; valid = v; clear = c;
    exp_err = v & (^w);
    if (c) tag = "R7";
    else if (!v) tag = "R5";
    else if (exp_err && exp_cnt == MAXV) tag = "R6";
    else if (exp_err) tag = "R4";
    else tag = "R8";
    if (c) exp_cnt = '0;
    else if (exp_err && exp_cnt != MAXV) exp_cnt = exp_cnt + 1'b1;
    @(posedge clk); #2;
    chk(v ? "R3" : "R5", {31'd0, err}, {31'd0, exp_err});
    chk(tag, {26'd0, cnt}, {26'd0, exp_cnt});
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; word = '0; valid = 1'b0; clear = 1'b0;
    exp_cnt = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1", {31'd0, err}, 32'd0);
    chk("R1", {26'd0, cnt}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R2 field layout: parity bit alone is odd, parity with one pad or bx bit is even
    step(15'h4000, 1'b1, 1'b0);
    chk("R2", {31'd0, err}, 32'd1);
    step(15'h4001, 1'b1, 1'b0);
    chk("R2", {31'd0, err}, 32'd0);
    step(15'h6000, 1'b1, 1'b0);
    chk("R2", {31'd0, err}, 32'd0);
    step(15'h1000, 1'b1, 1'b0);
    chk("R2", {31'd0, err}, 32'd1);

    // exhaustive sweep; clears every 300 words, some on bad words
    for (int i = 0; i < 32768; i++) begin
      step(i[14:0], 1'b1, (i % 300) == 299);
    end

    // saturation reached and held
    step(15'h0000, 1'b1, 1'b1);
    for (int i = 0; i < 80; i++) step(15'h0001, 1'b1, 1'b0);
    chk("R6", {26'd0, cnt}, {26'd0, MAXV});

    // clear on a bad word: clear wins
    step(15'h0001, 1'b1, 1'b1);
    chk("R7", {26'd0, cnt}, 32'd0);

    // unqualified bad words ignored
    step(15'h0001, 1'b1, 1'b0);
    for (int i = 0; i < 32768; i += 7) step(i[14:0], 1'b0, 1'b0);
    chk("R5", {26'd0, cnt}, 32'd1);

    // hold across idle cycles
    for (int i = 0; i < 20; i++) step(15'h0003, 1'b1, 1'b0);
    chk("R8", {26'd0, cnt}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule